// File: doc/BRIEF.md
# Result Compare Monitor

The block watches the conversion results of a multi-channel converter as each one is stored. It holds a set of independent compare units. Each unit selects one channel, a threshold, a direction (at-or-above or below) and a repeat count. Every stored result for the selected channel is compared with the threshold. A run of qualifying results that is long enough raises a sticky flag for that unit. When the unit's interrupt enable is set, the flag also drives an interrupt request.

A single strobe reports each result as it is stored. The strobe carries the channel number and the 12-bit result. A global format input tells the units whether results and thresholds are unsigned or two's-complement, and the compare follows that format. Software clears a flag with a one-cycle write-one pulse on that unit's clear input. The converter, the result storage and the scan sequencing sit outside this block.

Top module: `rcm_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every flag and every interrupt request is 0.
- R2: A unit considers a result only if its enable bit is 1, the strobe is high, and the strobe's 3-bit channel number equals the unit's channel select. It ignores results for other channels and results that arrive while it is disabled, and these leave its match counter unchanged.
- R3: With the condition bit at 1, a result greater than or equal to the threshold is a match. A result equal to the threshold matches.
- R4: With the condition bit at 0, only a result strictly less than the threshold is a match. A result equal to the threshold does not match.
- R5: Each match adds 1 to the unit's match counter. The flag reads 1 in the cycle after the strobe that carries match number N+1, where N is the unit's 4-bit repeat count. No flag is raised before that match.
- R6: A considered result that does not match returns the match counter to zero, so the run must start again.
- R7: A cycle with the unit's enable at 0 returns its match counter to zero. No flag can be raised in the cycle that follows it.
- R8: With the format input at 1, result and threshold are compared as signed 12-bit values. With the format input at 0, they are compared as unsigned values.
- R9: A flag stays set until a clear pulse arrives for that unit. It is then 0 in the next cycle. A clear pulse in the same cycle as a new flag-setting match leaves the flag at 1.
- R10: A unit's interrupt request is 1 exactly when its flag is 1 and its interrupt enable is 1.
- R11: Units are independent. A result can set one unit's flag without affecting another unit's flag or counter.
- R12: When the flag sets, the match counter returns to zero. A later flag event needs another N+1 matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_signed_i | input | 1 | 1: results and thresholds are two's-complement; 0: unsigned |
| res_load_i | input | 1 | A result is being stored this cycle |
| res_chan_i | input | CH_W (3) | Channel number of the stored result |
| res_data_i | input | RES_W (12) | Stored result value |
| cfg_en_i | input | N_UNITS (2) | Compare enable, one bit per unit |
| cfg_ie_i | input | N_UNITS (2) | Interrupt enable, one bit per unit |
| cfg_ge_i | input | N_UNITS (2) | Condition per unit: 1 at-or-above, 0 below |
| cfg_chan_i | input | N_UNITS*CH_W (6) | Channel select; unit u uses bits [u*3 +: 3] |
| cfg_rep_i | input | N_UNITS*MC_W (8) | Repeat count N; unit u uses bits [u*4 +: 4] |
| cfg_thr_i | input | N_UNITS*RES_W (24) | Threshold; unit u uses bits [u*12 +: 12] |
| flag_clr_i | input | N_UNITS (2) | Write-one clear pulse, one bit per unit |
| flag_o | output | N_UNITS (2) | Sticky compare flags, bit u for unit u |
| irq_o | output | N_UNITS (2) | Interrupt requests, bit u for unit u |

## Verification
The bench targets the threshold edge in both directions: a result equal to the threshold must count when the condition is at-or-above and must not count when it is below. Swapping > for >= would move the flag by one result. A run of matches is broken by a non-matching result, by a cycle with enable low, and is interleaved with results for other channels. A counter that ignored a reset would raise the flag early, and one that reset on any strobe would raise it late. Negative results are sent in signed format, where an unsigned compare gives the opposite answer. The bench also drives a clear in the same cycle as a new set, where a clear-first design would drop the flag. It then checks that a second flag event after a clear needs the full run of matches again.

// File: rtl/rcm_pkg.sv
// Package rcm_pkg
// Shared constants and types for the result compare monitor.
// Assumes: results are 12 bits wide and channel numbers are 3 bits wide.
package rcm_pkg;
    localparam int RCM_RES_W = 12;
    localparam int RCM_CH_W  = 3;
    localparam int RCM_MC_W  = 4;

    // Direction of the threshold test for one compare unit.
    typedef enum logic {
        CMP_BELOW       = 1'b0,
        CMP_AT_OR_ABOVE = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/rcm_cmp.sv
// Module rcm_cmp
// Combinational qualifier and threshold test for one compare unit.
// hit_o is 1 when the stored result belongs to this unit. match_o gives
// the result of the threshold test in the selected format.
// Assumes: the threshold uses the same format as the results.
module rcm_cmp #(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic             load_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [RES_W-1:0] data_i,
    input  logic             en_i,
    input  logic             ge_mode_i,
    input  logic [CH_W-1:0]  sel_i,
    input  logic [RES_W-1:0] thr_i,
    input  logic             fmt_signed_i,
    output logic             hit_o,
    output logic             match_o
);
    logic at_or_above;

    // Magnitude test, signed or unsigned according to the format input.
    always_comb begin
        if (fmt_signed_i) begin
            at_or_above = ($signed(data_i) >= $signed(thr_i));
        end else begin
            at_or_above = (data_i >= thr_i);
        end
    end

    // Result qualification and the direction chosen by the condition bit.
    always_comb begin
        hit_o   = load_i & en_i & (chan_i == sel_i);
        match_o = ge_mode_i ? at_or_above : ~at_or_above;
    end
endmodule

// File: rtl/rcm_cnt.sv
// Module rcm_cnt
// Match counter and sticky flag for one compare unit.
// The flag sets on the match that finds the counter at or above the
// repeat count, which is match number limit+1. The counter then restarts.
// A miss or a disabled cycle clears the counter. Set wins over clear.
// Assumes: synchronous active-low reset.
module rcm_cnt #(
    parameter int MC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            hit_i,
    input  logic            match_i,
    input  logic [MC_W-1:0] limit_i,
    input  logic            clr_i,
    output logic            flag_o
);
    logic [MC_W-1:0] cnt_q;
    logic            reach;

    // Run is complete when this match lands on a counter already at the limit.
    assign reach = hit_i & match_i & (cnt_q >= limit_i);

    // Counts consecutive qualifying results for the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (hit_i) begin
            if (!match_i || reach) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Sticky flag: set on run completion, cleared by write-one pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (reach) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rcm_monitor.sv
// Module rcm_monitor
// Top of the result compare monitor. N_UNITS compare units each watch
// the result-load strobe. Each unit has its own channel, threshold,
// direction and repeat count, a sticky flag and a gated interrupt.
// Assumes: the configuration inputs are held stable by a register block
// outside this module, and the clear inputs are single-cycle pulses.
module rcm_monitor #(
    parameter int N_UNITS = 2,
    parameter int RES_W   = rcm_pkg::RCM_RES_W,
    parameter int CH_W    = rcm_pkg::RCM_CH_W,
    parameter int MC_W    = rcm_pkg::RCM_MC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fmt_signed_i,
    input  logic                     res_load_i,
    input  logic [CH_W-1:0]          res_chan_i,
    input  logic [RES_W-1:0]         res_data_i,
    input  logic [N_UNITS-1:0]       cfg_en_i,
    input  logic [N_UNITS-1:0]       cfg_ie_i,
    input  logic [N_UNITS-1:0]       cfg_ge_i,
    input  logic [N_UNITS*CH_W-1:0]  cfg_chan_i,
    input  logic [N_UNITS*MC_W-1:0]  cfg_rep_i,
    input  logic [N_UNITS*RES_W-1:0] cfg_thr_i,
    input  logic [N_UNITS-1:0]       flag_clr_i,
    output logic [N_UNITS-1:0]       flag_o,
    output logic [N_UNITS-1:0]       irq_o
);
    import rcm_pkg::*;

    generate
        for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
            cmp_mode_e  mode;
            logic       hit;
            logic       match;

            // Decode this unit's condition bit into its direction.
            assign mode = cmp_mode_e'(cfg_ge_i[g]);

            rcm_cmp #(
                .RES_W (RES_W),
                .CH_W  (CH_W)
            ) cmp_i (
                .load_i       (res_load_i),
                .chan_i       (res_chan_i),
                .data_i       (res_data_i),
                .en_i         (cfg_en_i[g]),
                .ge_mode_i    (mode == CMP_AT_OR_ABOVE),
                .sel_i        (cfg_chan_i[g*CH_W +: CH_W]),
                .thr_i        (cfg_thr_i[g*RES_W +: RES_W]),
                .fmt_signed_i (fmt_signed_i),
                .hit_o        (hit),
                .match_o      (match)
            );

            rcm_cnt #(
                .MC_W (MC_W)
            ) cnt_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (cfg_en_i[g]),
                .hit_i   (hit),
                .match_i (match),
                .limit_i (cfg_rep_i[g*MC_W +: MC_W]),
                .clr_i   (flag_clr_i[g]),
                .flag_o  (flag_o[g])
            );

            // Interrupt request gated by this unit's enable.
            assign irq_o[g] = flag_o[g] & cfg_ie_i[g];
        end
    endgenerate
endmodule

// File: rtl/rcm_monitor_chk.sv
// Module rcm_monitor_chk
// Port-level checks on the result compare monitor, attached by bind.
// Assumes: synchronous active-low reset, and checks are off during reset.
module rcm_monitor_chk #(
    parameter int N_UNITS = 2,
    parameter int CH_W    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    res_load_i,
    input logic [CH_W-1:0]         res_chan_i,
    input logic [N_UNITS-1:0]      cfg_en_i,
    input logic [N_UNITS-1:0]      cfg_ie_i,
    input logic [N_UNITS*CH_W-1:0] cfg_chan_i,
    input logic [N_UNITS-1:0]      flag_clr_i,
    input logic [N_UNITS-1:0]      flag_o,
    input logic [N_UNITS-1:0]      irq_o
);
    generate
        for (genvar g = 0; g < N_UNITS; g++) begin : g_chk
            AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_o[g]) |-> $past(res_load_i && cfg_en_i[g] &&
                                          (res_chan_i == cfg_chan_i[g*CH_W +: CH_W]))); // R2
            AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_en_i[g] && !flag_o[g]) |=> !flag_o[g]); // R7
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[g] && !flag_clr_i[g]) |=> flag_o[g]); // R9
            AST_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_o[g]) |-> $past(flag_clr_i[g])); // R9
            AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[g] |-> (flag_o[g] && cfg_ie_i[g])); // R10
        end
    endgenerate
endmodule

bind rcm_monitor rcm_monitor_chk #(
    .N_UNITS (N_UNITS),
    .CH_W    (CH_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_load_i (res_load_i),
    .res_chan_i (res_chan_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_ie_i   (cfg_ie_i),
    .cfg_chan_i (cfg_chan_i),
    .flag_clr_i (flag_clr_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
);

// File: tb/rcm_monitor_tb_top.sv
// Scoreboard bench for rcm_monitor. The driver task applies one cycle of
// stimulus and queues the flag and irq values the requirements predict.
// The monitor pops each item after the clock edge and compares it.
module rcm_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt = 1'b0;
    logic        load = 1'b0;
    logic [2:0]  rchan = '0;
    logic [11:0] rdata = '0;
    logic [1:0]  en = '0, ie = '0, ge = '0, fclr = '0;
    logic [5:0]  chan = '0;
    logic [7:0]  rep = '0;
    logic [23:0] thr = '0;
    logic [1:0]  flag, irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    typedef struct {
        logic [1:0] f;
        logic [1:0] q;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    rcm_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_signed_i(fmt),
        .res_load_i(load), .res_chan_i(rchan), .res_data_i(rdata),
        .cfg_en_i(en), .cfg_ie_i(ie), .cfg_ge_i(ge), .cfg_chan_i(chan),
        .cfg_rep_i(rep), .cfg_thr_i(thr), .flag_clr_i(fclr),
        .flag_o(flag), .irq_o(irq)
    );

    // Monitor: after each edge, compare outputs with the oldest prediction.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                total++;
                if (flag !== it.f || irq !== it.q) begin
                    bad++;
                    $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
                             it.tag, flag, irq, it.f, it.q);
                end
            end
        end
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++;
                bad++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic cfg_unit(input int u, input bit e, input bit i, input bit g,
                            input int ch, input int r, input int t);
        en[u] = e;
        ie[u] = i;
        ge[u] = g;
        chan[u*3 +: 3] = ch[2:0];
        rep[u*4 +: 4] = r[3:0];
        thr[u*12 +: 12] = t[11:0];
    endtask

    // Driver: one cycle of stimulus plus the predicted outputs after the edge.
    task automatic step(input bit ld, input int ch, input int d,
                        input logic [1:0] clr, input logic [1:0] ef, input string tag);
        @(negedge clk);
        load  = ld;
        rchan = ch[2:0];
        rdata = d[11:0];
        fclr  = clr;
        sb.push_back('{ef, ef & ie, tag});
        @(posedge clk);
        #3;
        load = 1'b0;
        fclr = 2'b00;
    endtask

    // Clear both flags and counters with a disabled cycle.
    task automatic quiesce();
        en = 2'b00;
        step(0, 0, 0, 2'b11, 2'b00, "R9 quiesce");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (flag !== 2'b00 || irq !== 2'b00) begin
            bad++;
            $display("FAIL R1: flag=%b irq=%b expected 00 00 in reset", flag, irq);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        total++;
        if (flag !== 2'b00 || irq !== 2'b00) begin
            bad++;
            $display("FAIL R1: flag=%b irq=%b expected 00 00 after reset", flag, irq);
        end
        #1;

        // R3/R5: at-or-above, three matches needed, equal value counts.
        cfg_unit(0, 1, 1, 1, 2, 2, 'h400);
        step(1, 2, 'h400, 2'b00, 2'b00, "R3 equal counts");
        step(1, 2, 'h7FF, 2'b00, 2'b00, "R5 second match");
        step(1, 2, 'h500, 2'b00, 2'b01, "R5 third match sets");
        step(0, 0, 0, 2'b00, 2'b01, "R9 sticky");
        step(0, 0, 0, 2'b01, 2'b00, "R9 clear");

        // R2: results for other channels are ignored.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 1, 'h400);
        step(1, 2, 'h500, 2'b00, 2'b00, "R2 first");
        step(1, 3, 'h000, 2'b00, 2'b00, "R2 other channel");
        step(1, 2, 'h500, 2'b00, 2'b01, "R2 run unbroken");

        // R6: a miss restarts the run.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 1, 'h400);
        step(1, 2, 'h500, 2'b00, 2'b00, "R6 first");
        step(1, 2, 'h100, 2'b00, 2'b00, "R6 miss");
        step(1, 2, 'h500, 2'b00, 2'b00, "R6 restart");
        step(1, 2, 'h500, 2'b00, 2'b01, "R6 second after miss");

        // R4: strictly below, equal does not count.
        quiesce();
        cfg_unit(0, 1, 1, 0, 2, 0, 'h400);
        step(1, 2, 'h400, 2'b00, 2'b00, "R4 equal no match");
        step(1, 2, 'h3FF, 2'b00, 2'b01, "R4 below matches");

        // R7: a disabled cycle resets the counter; R2: disabled strobe ignored.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 1, 'h400);
        step(1, 2, 'h500, 2'b00, 2'b00, "R7 first");
        en[0] = 1'b0;
        step(1, 2, 'h500, 2'b00, 2'b00, "R2 disabled strobe");
        en[0] = 1'b1;
        step(1, 2, 'h500, 2'b00, 2'b00, "R7 counter was reset");
        step(1, 2, 'h500, 2'b00, 2'b01, "R7 run completes");

        // R8: signed compare.
        quiesce();
        fmt = 1'b1;
        cfg_unit(0, 1, 1, 1, 2, 0, 'h000);
        step(1, 2, 'h800, 2'b00, 2'b00, "R8 negative below zero");
        step(1, 2, 'h001, 2'b00, 2'b01, "R8 positive at-or-above");
        quiesce();
        cfg_unit(0, 1, 1, 0, 2, 0, 'h000);
        step(1, 2, 'hFFF, 2'b00, 2'b01, "R8 minus one below zero");
        quiesce();
        fmt = 1'b0;
        cfg_unit(0, 1, 1, 0, 2, 0, 'h000);
        step(1, 2, 'hFFF, 2'b00, 2'b00, "R8 unsigned 4095 not below");

        // R9: clear and set in the same cycle leaves the flag set.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 0, 'h000);
        step(1, 2, 'h005, 2'b00, 2'b01, "R9 set");
        step(1, 2, 'h005, 2'b01, 2'b01, "R9 set beats clear");

        // R10: irq follows the interrupt enable.
        ie[0] = 1'b0;
        step(0, 0, 0, 2'b00, 2'b01, "R10 irq masked");
        ie[0] = 1'b1;
        step(0, 0, 0, 2'b00, 2'b01, "R10 irq unmasked");

        // R12: after a set, a full new run is needed.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 1, 'h000);
        step(1, 2, 'h010, 2'b00, 2'b00, "R12 first");
        step(1, 2, 'h010, 2'b00, 2'b01, "R12 set");
        step(0, 0, 0, 2'b01, 2'b00, "R12 clear");
        step(1, 2, 'h010, 2'b00, 2'b00, "R12 counter restarted");
        step(1, 2, 'h010, 2'b00, 2'b01, "R12 second set");

        // R11: two units act on their own channels.
        quiesce();
        cfg_unit(0, 1, 1, 1, 2, 0, 'h000);
        cfg_unit(1, 1, 1, 0, 5, 0, 'h100);
        step(1, 5, 'h050, 2'b00, 2'b10, "R11 unit1 only");
        step(1, 2, 'h001, 2'b00, 2'b11, "R11 unit0 also");
        step(0, 0, 0, 2'b10, 2'b01, "R11 clear unit1 only");
        step(0, 0, 0, 2'b01, 2'b00, "R11 clear unit0");

        repeat (3) @(posedge clk);
        #3;
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: pending=%0d expected 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule